// File: doc/BRIEF.md
# Shadowed SRAM store/recall controller

This block manages a word-addressed SRAM that has a nonvolatile twin of the same size. The host uses an asynchronous-style port with active-low chip enable, write enable and output enable. The port is sampled on the system clock. Writes go into the SRAM, and reads return SRAM data one clock later.

Two bulk transfers move data between the two arrays. A store copies the whole SRAM into the nonvolatile array. Before copying, the block pulls a shared open-drain handshake line low for a set number of cycles. A recall first zeroes every SRAM word and then reloads every word from the nonvolatile array. A recall is started only by six host reads to a fixed list of addresses, in order.

Several protections stop unintended data changes. A low-voltage flag blocks host writes and requested stores. A write that is already held active at power-up, or at the end of a store or recall, stays blocked until chip enable or write enable falls. An automatic store, started when the supply fails, abandons itself if the handshake line does not actually go low.

Top module: `nvshadow_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `busy` and `hs_drive` are low and `rdata` is zero.
- R2: When the block is idle, a cycle with `ce_n`=0 and `we_n`=0 writes `wdata` to word `addr[IW-1:0]`, where IW = log2(DEPTH). A cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1 puts that word on `rdata` after the next rising edge.
- R3: A read starts on the cycle where `ce_n` falls while `we_n`=1. Six read starts to UNLK0..UNLK5 in that order start a recall. The default last three addresses are 0x1FFF, 0x10F0 and 0x0F0E. `busy` rises on the edge that takes the last read.
- R4: A read start to an address other than the next expected one restarts the unlock match. A write cycle also restarts it. In both cases no recall starts.
- R5: A recall keeps `busy` high for exactly RECALL_CYC cycles. It zeroes every word and then loads every word from the nonvolatile array, so afterwards each SRAM word equals the stored image.
- R6: A recall never changes the nonvolatile array, so repeated recalls give the same image.
- R7: While `busy` is high, host writes have no effect and `rdata` holds its last value.
- R8: While `lowv` is high, host writes have no effect, and `store_req` does not start a store.
- R9: A write held active (`ce_n`=`we_n`=0) through reset release, or through the end of a store or recall, is blocked until `ce_n` or `we_n` falls.
- R10: `store_req` while idle starts a store. `hs_drive` is high for HS_CYC cycles, then the SRAM is copied to the nonvolatile array, and `busy` stays high for HS_CYC+DEPTH cycles in total.
- R11: `auto_store` starts a store even when `lowv` is high. If `hs_sense` reads high on handshake cycle SENSE_DLY, the block releases the line and abandons the store. It stays busy for SENSE_DLY+1 cycles and leaves the nonvolatile array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| lowv | input | 1 | Low-supply flag |
| store_req | input | 1 | Host store request |
| auto_store | input | 1 | Supply-fail store request |
| hs_sense | input | 1 | Sampled level of the shared handshake line |
| hs_drive | output | 1 | Pull the handshake line low |
| busy | output | 1 | Store or recall in progress |

## Verification
Most faults in the sequencer or the unlock matcher show up as a wrong `busy` length. A wrong counter limit changes the measured cycle count of a store, recall or abort by at least one cycle. A matcher that fails to restart either gives an unexpected `busy` pulse on the edge of the sixth read, or gives no pulse where one is expected.

A wrong array index or a wrong copy direction does not show at once. It appears on `rdata` only when every word is read back after the next recall, which takes one full sweep of the array.

A write gate that clears or arms at the wrong time shows as a corrupted word on the first read after the hold is released.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_RCL   = 2'd1,
      SQ_SHAKE = 2'd2,
      SQ_COPY  = 2'd3
   } sq_state_t;

   localparam int NKEY = 6;
endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock #(
   parameter int AW = 13,
   parameter logic [nvs_pkg::NKEY*AW-1:0] KEYS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          rd_start,
   input  logic          wr_cyc,
   input  logic [AW-1:0] addr,
   output logic          go
);
   localparam int NK = nvs_pkg::NKEY;
   localparam int SW = $clog2(NK);
   localparam logic [SW-1:0] LAST = SW'(NK - 1);

   logic [NK-1:0] hit;
   logic [SW-1:0] stage;

   for (genvar i = 0; i < NK; i++) begin : g_key
      assign hit[i] = (addr == KEYS[i*AW +: AW]);
   end

   assign go = en && rd_start && (stage == LAST) && hit[stage];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
      end else if (!en || wr_cyc) begin
         stage <= '0;
      end else if (rd_start) begin
         if (hit[stage])
            stage <= (stage == LAST) ? '0 : stage + 1'b1;
         else
            stage <= hit[0] ? SW'(1) : '0;
      end
   end
endmodule

// File: rtl/nvs_wgate.sv
module nvs_wgate (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic arm,
   output logic block
);
   logic ce_q, we_q, gate;
   logic fall;

   assign fall  = (ce_q && !ce_n) || (we_q && !we_n);
   assign block = gate && !fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q <= 1'b0;
         we_q <= 1'b0;
         gate <= 1'b1;
      end else begin
         ce_q <= ce_n;
         we_q <= we_n;
         if (arm)
            gate <= 1'b1;
         else if (fall)
            gate <= 1'b0;
      end
   end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int DEPTH      = 256,
   parameter int RECALL_CYC = 600,
   parameter int HS_CYC     = 1000,
   parameter int SENSE_DLY  = 2,
   parameter int IW         = 8,
   parameter int CW         = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rcl_go,
   input  logic          st_go,
   input  logic          auto_go,
   input  logic          hs_sense,
   output logic          busy,
   output logic          hs_drive,
   output logic          done,
   output logic          clr_en,
   output logic          rcl_cp_en,
   output logic          st_cp_en,
   output logic [IW-1:0] idx
);
   localparam logic [CW-1:0] RCL_END = CW'(RECALL_CYC - 1);
   localparam logic [CW-1:0] HS_END  = CW'(HS_CYC - 1);
   localparam logic [CW-1:0] CP_END  = CW'(DEPTH - 1);
   localparam logic [CW-1:0] D1      = CW'(DEPTH);
   localparam logic [CW-1:0] D2      = CW'(2 * DEPTH);
   localparam logic [CW-1:0] SNS     = CW'(SENSE_DLY);

   sq_state_t     st;
   logic [CW-1:0] cnt;
   logic          auto_q;

   assign busy      = (st != SQ_IDLE);
   assign hs_drive  = (st == SQ_SHAKE);
   assign clr_en    = (st == SQ_RCL) && (cnt < D1);
   assign rcl_cp_en = (st == SQ_RCL) && (cnt >= D1) && (cnt < D2);
   assign st_cp_en  = (st == SQ_COPY);
   assign idx       = cnt[IW-1:0];
   assign done      = ((st == SQ_RCL) && (cnt == RCL_END)) ||
                      ((st == SQ_COPY) && (cnt == CP_END));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         cnt    <= '0;
         auto_q <= 1'b0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               cnt <= '0;
               if (rcl_go) begin
                  st <= SQ_RCL;
               end else if (st_go || auto_go) begin
                  st     <= SQ_SHAKE;
                  auto_q <= auto_go;
               end
            end
            SQ_RCL: begin
               if (cnt == RCL_END) begin
                  st  <= SQ_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_SHAKE: begin
               if (auto_q && (cnt == SNS) && hs_sense) begin
                  st  <= SQ_IDLE;
                  cnt <= '0;
               end else if (cnt == HS_END) begin
                  st  <= SQ_COPY;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_COPY: begin
               if (cnt == CP_END) begin
                  st  <= SQ_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl #(
   parameter int DW         = 8,
   parameter int AW         = 13,
   parameter int DEPTH      = 256,
   parameter int RECALL_CYC = 600,
   parameter int HS_CYC     = 1000,
   parameter int SENSE_DLY  = 2,
   parameter logic [AW-1:0] UNLK0 = 13'h0E38,
   parameter logic [AW-1:0] UNLK1 = 13'h11C7,
   parameter logic [AW-1:0] UNLK2 = 13'h03E0,
   parameter logic [AW-1:0] UNLK3 = 13'h1FFF,
   parameter logic [AW-1:0] UNLK4 = 13'h10F0,
   parameter logic [AW-1:0] UNLK5 = 13'h0F0E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          lowv,
   input  logic          store_req,
   input  logic          auto_store,
   input  logic          hs_sense,
   output logic          hs_drive,
   output logic          busy
);
   localparam int IW   = $clog2(DEPTH);
   localparam int MAXC = (RECALL_CYC > HS_CYC + DEPTH) ? RECALL_CYC : HS_CYC + DEPTH;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [nvs_pkg::NKEY*AW-1:0] KEYS = {UNLK5, UNLK4, UNLK3, UNLK2, UNLK1, UNLK0};

   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (AW < IW) begin : g_bad_aw
      $error("AW too narrow for DEPTH");
   end
   if (RECALL_CYC < 2 * DEPTH) begin : g_bad_rcl
      $error("RECALL_CYC must cover clear and copy phases");
   end
   if (SENSE_DLY >= HS_CYC) begin : g_bad_sense
      $error("SENSE_DLY must fall inside the handshake window");
   end

   logic [DW-1:0] sram [DEPTH];
   logic [DW-1:0] nvm  [DEPTH];

   logic          ce_q;
   logic          rd_start, wr_cyc, wr_en, rd_cyc;
   logic          rcl_go, st_go, auto_go, done, wblock;
   logic          clr_en, rcl_cp_en, st_cp_en;
   logic [IW-1:0] idx;
   logic [IW-1:0] a;

   assign a        = addr[IW-1:0];
   assign wr_cyc   = !ce_n && !we_n;
   assign rd_cyc   = !ce_n && !oe_n && we_n;
   assign rd_start = ce_q && !ce_n && we_n && !busy;
   assign wr_en    = wr_cyc && !busy && !lowv && !wblock;
   assign st_go    = store_req && !lowv && !busy;
   assign auto_go  = auto_store && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_q <= 1'b0;
      else        ce_q <= ce_n;
   end

   nvs_unlock #(.AW(AW), .KEYS(KEYS)) u_unlock (
      .clk(clk), .rst_n(rst_n), .en(!busy), .rd_start(rd_start),
      .wr_cyc(wr_cyc), .addr(addr), .go(rcl_go)
   );

   nvs_wgate u_wgate (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .arm(done), .block(wblock)
   );

   nvs_seq #(
      .DEPTH(DEPTH), .RECALL_CYC(RECALL_CYC), .HS_CYC(HS_CYC),
      .SENSE_DLY(SENSE_DLY), .IW(IW), .CW(CW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .rcl_go(rcl_go), .st_go(st_go),
      .auto_go(auto_go), .hs_sense(hs_sense), .busy(busy),
      .hs_drive(hs_drive), .done(done), .clr_en(clr_en),
      .rcl_cp_en(rcl_cp_en), .st_cp_en(st_cp_en), .idx(idx)
   );

   always_ff @(posedge clk) begin
      if (clr_en)
         sram[idx] <= '0;
      else if (rcl_cp_en)
         sram[idx] <= nvm[idx];
      else if (wr_en)
         sram[a] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (st_cp_en)
         nvm[idx] <= sram[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (!busy && rd_cyc)
         rdata <= sram[a];
   end
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          hs_drive,
   input logic [DW-1:0] rdata,
   input logic          lowv,
   input logic          store_req,
   input logic          auto_store,
   input logic          rcl_go,
   input logic          ce_n,
   input logic          we_n,
   input logic          wr_en
);
   // R7
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(rdata));

   // R3
   unlock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rcl_go |=> busy);

   // R8
   lowv_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lowv && store_req && !auto_store && !rcl_go && !busy) |=> !busy);

   // R10
   shake_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_drive |-> busy);

   // R9
   held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy) && !ce_n && !we_n && $past(!ce_n && !we_n)) |-> !wr_en);
endmodule

bind nvshadow_ctrl nvs_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .hs_drive(hs_drive),
   .rdata(rdata), .lowv(lowv), .store_req(store_req),
   .auto_store(auto_store), .rcl_go(rcl_go), .ce_n(ce_n),
   .we_n(we_n), .wr_en(wr_en)
);

// File: tb/sim_nvshadow_ctrl.sv
module sim_nvshadow_ctrl;
   localparam int DW = 8, AW = 13, DEPTH = 16;
   localparam int RCLC = 40, HSC = 8, SNS = 2;
   localparam logic [AW-1:0] K0 = 13'h0E38, K1 = 13'h11C7, K2 = 13'h03E0;
   localparam logic [AW-1:0] K3 = 13'h1FFF, K4 = 13'h10F0, K5 = 13'h0F0E;

   logic clk = 0, rst_n = 0;
   logic ce_n = 1, we_n = 1, oe_n = 1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic lowv = 0, store_req = 0, auto_store = 0, force_hi = 0;
   logic hs_sense, hs_drive, busy;

   int total = 0, fails = 0;
   int exp_s [DEPTH];
   int exp_n [DEPTH];

   assign hs_sense = force_hi | ~hs_drive;
   always #10 clk = ~clk;

   nvshadow_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .RECALL_CYC(RCLC),
      .HS_CYC(HSC), .SENSE_DLY(SNS), .UNLK0(K0), .UNLK1(K1), .UNLK2(K2),
      .UNLK3(K3), .UNLK4(K4), .UNLK5(K5)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .lowv(lowv),
      .store_req(store_req), .auto_store(auto_store), .hs_sense(hs_sense),
      .hs_drive(hs_drive), .busy(busy));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output int v);
      ce_n = 0; oe_n = 0; we_n = 1; addr = a;
      @(negedge clk);
      v = int'(rdata);
      ce_n = 1; oe_n = 1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input int d);
      ce_n = 0; we_n = 0; addr = a; wdata = DW'(d);
      @(negedge clk);
      ce_n = 1; we_n = 1;
      @(negedge clk);
   endtask

   task automatic run_out(inout int n, inout int h);
      int g = 0;
      while (busy && g < 2000) begin
         @(negedge clk);
         n += int'(busy); h += int'(hs_drive & busy); g++;
      end
   endtask

   // Full unlock; hold=1 keeps a write active through completion.
   task automatic recall(input bit hold, input int ha, output int n);
      int v, h = 0;
      rd(K0, v); rd(K1, v); rd(K2, v); rd(K3, v); rd(K4, v);
      ce_n = 0; oe_n = 0; we_n = 1; addr = K5;
      @(negedge clk);
      chk("R3 busy after sixth read", int'(busy), 1);
      if (hold) begin
         oe_n = 1; we_n = 0; addr = AW'(ha); wdata = 8'h5A;
      end else begin
         ce_n = 1; oe_n = 1;
      end
      n = int'(busy);
      run_out(n, h);
      for (int i = 0; i < DEPTH; i++) exp_s[i] = exp_n[i];
   endtask

   task automatic check_all(input string req);
      int v;
      for (int i = 0; i < DEPTH; i++) begin
         rd(AW'(i), v);
         chk(req, v, exp_s[i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int v, n, h;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 hs_drive", int'(hs_drive), 0);
      chk("R1 rdata", int'(rdata), 0);
      @(negedge clk);

      // R2 sweep
      for (int i = 0; i < DEPTH; i++) begin
         exp_s[i] = (i * 37 + 5) & 8'hFF;
         wr(AW'(i), exp_s[i]);
      end
      check_all("R2 readback");

      // R10 store
      store_req = 1;
      @(negedge clk);
      store_req = 0;
      n = int'(busy); h = int'(hs_drive);
      run_out(n, h);
      chk("R10 busy length", n, HSC + DEPTH);
      chk("R10 handshake length", h, HSC);
      for (int i = 0; i < DEPTH; i++) exp_n[i] = exp_s[i];

      // R5 recall after overwriting
      for (int i = 0; i < DEPTH; i++) begin
         exp_s[i] = (i * 11 + 200) & 8'hFF;
         wr(AW'(i), exp_s[i]);
      end
      recall(0, 0, n);
      chk("R5 recall length", n, RCLC);
      check_all("R5 image restored");

      // R6 second recall
      for (int i = 0; i < DEPTH; i++) begin
         exp_s[i] = i ^ 8'h3C;
         wr(AW'(i), exp_s[i]);
      end
      recall(0, 0, n);
      chk("R6 repeat recall length", n, RCLC);
      check_all("R6 image unchanged");

      // R4 mismatched read
      rd(K0, v); rd(K1, v); rd(K2, v); rd(K3, v); rd(AW'(5), v);
      rd(K4, v); rd(K5, v);
      chk("R4 mismatch no recall", int'(busy), 0);
      // R4 write inside sequence
      rd(K0, v); rd(K1, v); rd(K2, v); rd(K3, v);
      wr(AW'(6), 8'h77); exp_s[6] = 8'h77;
      rd(K4, v); rd(K5, v);
      chk("R4 write no recall", int'(busy), 0);
      rd(AW'(6), v);
      chk("R4 data intact", v, 8'h77);

      // R7 write and read attempts while busy
      begin
         int r0, hh = 0;
         rd(K0, v); rd(K1, v); rd(K2, v); rd(K3, v); rd(K4, v);
         rd(K5, v);
         r0 = int'(rdata);
         repeat (3) @(negedge clk);
         ce_n = 0; we_n = 0; addr = AW'(3); wdata = 8'hAA;
         @(negedge clk);
         ce_n = 1; we_n = 1;
         @(negedge clk);
         ce_n = 0; oe_n = 0; addr = AW'(9);
         @(negedge clk);
         ce_n = 1; oe_n = 1;
         chk("R7 rdata held", int'(rdata), r0);
         n = 0;
         run_out(n, hh);
         for (int i = 0; i < DEPTH; i++) exp_s[i] = exp_n[i];
         rd(AW'(3), v);
         chk("R7 busy write ignored", v, exp_n[3]);
      end

      // R8 low voltage
      lowv = 1;
      wr(AW'(1), 8'hEE);
      rd(AW'(1), v);
      chk("R8 write blocked", v, exp_s[1]);
      store_req = 1;
      @(negedge clk);
      store_req = 0;
      chk("R8 store blocked", int'(busy), 0);
      lowv = 0;

      // R9 write held through recall end
      recall(1, 4, n);
      repeat (3) @(negedge clk);
      ce_n = 1; we_n = 1;
      @(negedge clk);
      rd(AW'(4), v);
      chk("R9 held write after recall", v, exp_n[4]);
      wr(AW'(4), 8'h12); exp_s[4] = 8'h12;
      rd(AW'(4), v);
      chk("R9 write after fall", v, 8'h12);

      // R9 write held through reset release
      ce_n = 0; we_n = 0; addr = AW'(2); wdata = 8'hC3;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      ce_n = 1; we_n = 1;
      @(negedge clk);
      rd(AW'(2), v);
      chk("R9 held write at power-up", v, exp_s[2]);

      // R11 auto store abort
      for (int i = 0; i < DEPTH; i++) begin
         exp_s[i] = (i * 5 + 1) & 8'hFF;
         wr(AW'(i), exp_s[i]);
      end
      force_hi = 1; auto_store = 1;
      @(negedge clk);
      auto_store = 0;
      n = int'(busy); h = 0;
      run_out(n, h);
      force_hi = 0;
      chk("R11 abort length", n, SNS + 1);
      chk("R11 line released", int'(hs_drive), 0);
      recall(0, 0, n);
      check_all("R11 image kept");

      // R11 auto store under low voltage
      for (int i = 0; i < DEPTH; i++) begin
         exp_s[i] = (i * 9 + 100) & 8'hFF;
         wr(AW'(i), exp_s[i]);
      end
      lowv = 1; auto_store = 1;
      @(negedge clk);
      auto_store = 0;
      n = int'(busy); h = int'(hs_drive);
      run_out(n, h);
      lowv = 0;
      chk("R11 auto store length", n, HSC + DEPTH);
      for (int i = 0; i < DEPTH; i++) exp_n[i] = exp_s[i];
      for (int i = 0; i < DEPTH; i++) wr(AW'(i), 0);
      recall(0, 0, n);
      check_all("R11 auto store image");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule